// File: doc/BRIEF.md
# Programmable PN Symbol Spreader/Correlator

This block carries three data bits per transmitted symbol by sending one of eight 32-chip pseudo-noise patterns. The eight patterns come from four host-programmable code words. Each code word is sent either as written or bitwise complemented. The spread ratio is therefore 32 chips per 3 bits, about 10.667. On transmit, a symbol is accepted through a valid/ready pair. Its chips are then shifted out, least significant first, one per pulse of an external chip strobe. The ready signal rises on the last chip, so a following symbol continues with no idle chip between the two.

On receive, the block takes one-bit hard-decision samples at twice the chip rate, paced by an external sample strobe. It correlates each 64-sample window against all four code words at once. The sign of a correlation tells a code from its complement, so four counters cover all eight candidates. At the end of a window, the block reports the best-matching symbol and a 4-bit strength value. Two host bits invert the transmitted chip stream and the received sample stream independently. A window-restart input lets the surrounding timing logic realign the receive window.

Top module: `pnsc_top`

## Requirements
- R1: While `cfg_we` is high, `cfg_wdata` is stored as code word number `cfg_addr` (0..3) at the clock edge. Bit k of a code word is chip k. Reset clears all four code words to zero.
- R2: Symbol mapping: a symbol with bit 2 clear uses code word `sym[1:0]` as written. A symbol with bit 2 set uses code word `~sym[1:0]`, bitwise complemented. So 000/111 share code 0, 001/110 share code 1, 010/101 share code 2, and 011/100 share code 3.
- R3: Chip k (k = 0..31) of an accepted symbol is bit k of its mapped pattern XOR `tx_inv`. Chip 0 appears in the cycle after acceptance. The chip advances only at a clock edge where `chip_en` is high, and holds otherwise. The 32nd `chip_en` edge ends the symbol. While no symbol is being sent, `tx_chip` is 0.
- R4: `tx_ready` is high while no symbol is being sent. While a symbol is being sent, it is high only in a cycle where the last chip is on the output and `chip_en` is high. A symbol accepted at that edge puts its chip 0 on the output in the very next cycle, with no gap.
- R5: A symbol is taken only at an edge where `tx_sym_valid` and `tx_ready` are both high. A `tx_sym_valid` in any other cycle has no effect on the chip stream.
- R6: Each receive sample is `rx_smp XOR rx_inv`, taken at an edge where `smp_en` is high. Sample j (0..63) of a window is compared with chip j>>1 of each code word.
- R7: For each code c, let A_c be the number of the 64 samples that agree with it, and let the correlation be 2*A_c - 64. The code with the largest absolute correlation wins, and ties go to the lowest code index. A non-negative correlation decodes to symbol {0,c}. A negative correlation decodes to symbol {1,~c}.
- R8: `rx_strength` is the winner's absolute correlation divided by 4, saturated at 15. A clean window therefore gives 15.
- R9: `rx_valid` is a one-cycle pulse in the cycle after the edge that takes a window's 64th sample. `rx_sym` and `rx_strength` change only with that pulse and hold until the next one.
- R10: `rx_sync` high at an edge discards the partial window. If `smp_en` is also high at that edge, its sample becomes sample 0 of the new window.
- R11: Reset state: `tx_ready` is 1, `tx_chip` is 0, `rx_valid` is 0, and `rx_sym` and `rx_strength` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Code word write strobe |
| cfg_addr | input | 2 | Code word number to write |
| cfg_wdata | input | 32 | Code word value, bit k is chip k |
| tx_inv | input | 1 | Invert the transmitted chip stream |
| rx_inv | input | 1 | Invert the received samples |
| tx_sym_valid | input | 1 | Transmit symbol offered |
| tx_sym | input | 3 | Transmit symbol |
| tx_ready | output | 1 | Transmit symbol can be taken this cycle |
| chip_en | input | 1 | Chip-rate strobe |
| tx_chip | output | 1 | Spread chip output |
| smp_en | input | 1 | Sample strobe at twice the chip rate |
| rx_smp | input | 1 | Hard-decision receive sample |
| rx_sync | input | 1 | Restart the receive window |
| rx_valid | output | 1 | Decoded symbol pulse |
| rx_sym | output | 3 | Decoded symbol |
| rx_strength | output | 4 | Correlation strength, 0 to 15 |

## Verification
The transmit side is swept over all eight symbols, back to back, with both output polarities. This separates the as-written and complemented halves of each code pair, checks the LSB-first chip order, and confirms the gapless handoff. A mid-symbol offer that must be ignored is mixed in. The receive side is swept over every symbol at several deterministic error counts (0, 6, 14, 24 and 40 flipped samples) and both input polarities. Clean windows confirm the symbol choice at full strength. Moderate errors exercise the strength scaling. Heavy errors push the correlation sign and the winner choice to where a wrong code index, a wrong sign rule or a wrong tie rule would show. A restart mid-window, taken together with a sample, shows that partial windows are discarded and that the coincident sample is kept.

// File: rtl/pnsc_pkg.sv
package pnsc_pkg;

    // Three data bits per symbol, served by four code words with two phases each.
    localparam int SYM_W  = 3;
    localparam int NCODES = 4;
    localparam int CIDX_W = 2;

    typedef logic [SYM_W-1:0]  sym_t;
    typedef logic [CIDX_W-1:0] cidx_t;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    // Which code word a symbol uses and whether it is sent complemented.
    typedef struct packed {
        cidx_t idx;
        logic  comp;
    } sym_map_t;

    function automatic sym_map_t map_sym(input sym_t s);
        sym_map_t m;
        m.comp = s[SYM_W-1];
        m.idx  = s[SYM_W-1] ? ~s[CIDX_W-1:0] : s[CIDX_W-1:0];
        return m;
    endfunction

    function automatic sym_t unmap_sym(input cidx_t i, input logic comp);
        return comp ? {1'b1, ~i} : {1'b0, i};
    endfunction

endpackage

// File: rtl/pnsc_code_bank.sv
module pnsc_code_bank
    import pnsc_pkg::*;
#(
    parameter int CHIPS = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we,
    input  cidx_t                          addr,
    input  logic [CHIPS-1:0]               wdata,
    output logic [NCODES-1:0][CHIPS-1:0]   codes
);

    for (genvar c = 0; c < NCODES; c++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                codes[c] <= '0;
            end else if (we && addr == cidx_t'(c)) begin
                codes[c] <= wdata;
            end
        end
    end

endmodule

// File: rtl/pnsc_tx_spreader.sv
module pnsc_tx_spreader
    import pnsc_pkg::*;
#(
    parameter int CHIPS = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NCODES-1:0][CHIPS-1:0]   codes,
    input  logic                           tx_inv,
    input  logic                           sym_valid,
    input  sym_t                           sym,
    output logic                           ready,
    input  logic                           chip_en,
    output logic                           chip
);

    localparam int CNT_W = (CHIPS > 1) ? $clog2(CHIPS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHIPS - 1);

    tx_state_e        state;
    logic [CHIPS-1:0] shreg;
    logic [CNT_W-1:0] cnt;
    logic             take;
    sym_map_t         m;
    logic [CHIPS-1:0] pattern;

    assign m       = map_sym(sym);
    assign pattern = m.comp ? ~codes[m.idx] : codes[m.idx];

    // Ready on the last chip's strobe lets the next symbol follow without a gap.
    assign ready = (state == TX_IDLE) || (cnt == LAST && chip_en);
    assign take  = sym_valid && ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TX_IDLE;
            shreg <= '0;
            cnt   <= '0;
        end else if (take) begin
            state <= TX_SEND;
            shreg <= pattern;
            cnt   <= '0;
        end else if (state == TX_SEND && chip_en) begin
            if (cnt == LAST) begin
                state <= TX_IDLE;
                cnt   <= '0;
            end else begin
                shreg <= shreg >> 1;
                cnt   <= cnt + 1'b1;
            end
        end
    end

    assign chip = (state == TX_SEND) ? (shreg[0] ^ tx_inv) : 1'b0;

endmodule

// File: rtl/pnsc_decider.sv
module pnsc_decider
    import pnsc_pkg::*;
#(
    parameter int SMP   = 64,
    parameter int ACC_W = 7,
    parameter int STR_W = 4
) (
    input  logic [NCODES-1:0][ACC_W-1:0] agree,
    output sym_t                         sym,
    output logic [STR_W-1:0]             strength
);

    localparam logic [ACC_W-1:0] HALF    = ACC_W'(SMP / 2);
    // Magnitude is kept in agreement units (|corr|/2); strength is |corr|/4.
    localparam int               STR_SH  = $clog2(SMP) - 1 - STR_W;
    localparam logic [ACC_W-1:0] STR_MAX = ACC_W'((1 << STR_W) - 1);

    logic [NCODES-1:0][ACC_W-1:0] mag;
    logic [NCODES-1:0]            neg;

    for (genvar c = 0; c < NCODES; c++) begin : g_mag
        assign neg[c] = agree[c] < HALF;
        assign mag[c] = neg[c] ? (HALF - agree[c]) : (agree[c] - HALF);
    end

    cidx_t            best_i;
    logic [ACC_W-1:0] best_m;
    logic [ACC_W-1:0] scaled;

    always_comb begin
        best_i = '0;
        best_m = mag[0];
        for (int c = 1; c < NCODES; c++) begin
            if (mag[c] > best_m) begin
                best_m = mag[c];
                best_i = cidx_t'(c);
            end
        end
        scaled   = best_m >> STR_SH;
        sym      = unmap_sym(best_i, neg[best_i]);
        strength = (scaled > STR_MAX) ? STR_MAX[STR_W-1:0] : scaled[STR_W-1:0];
    end

endmodule

// File: rtl/pnsc_rx_correlator.sv
module pnsc_rx_correlator
    import pnsc_pkg::*;
#(
    parameter int CHIPS = 32,
    parameter int OVS   = 2,
    parameter int STR_W = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NCODES-1:0][CHIPS-1:0]   codes,
    input  logic                           rx_inv,
    input  logic                           smp_en,
    input  logic                           smp,
    input  logic                           sync,
    output logic                           valid,
    output sym_t                           sym,
    output logic [STR_W-1:0]               strength
);

    localparam int SMP    = CHIPS * OVS;
    localparam int SC_W   = $clog2(SMP);
    localparam int OVS_SH = $clog2(OVS);
    localparam int CI_W   = SC_W - OVS_SH;
    localparam int ACC_W  = $clog2(SMP + 1);
    localparam logic [SC_W-1:0] LAST = SC_W'(SMP - 1);

    logic [SC_W-1:0]              cnt;
    logic [SC_W-1:0]              base_cnt;
    logic [CI_W-1:0]              chip_idx;
    logic                         s;
    logic                         done;
    logic [NCODES-1:0][ACC_W-1:0] acc;
    logic [NCODES-1:0][ACC_W-1:0] acc_nxt;

    assign s        = smp ^ rx_inv;
    assign base_cnt = sync ? '0 : cnt;
    assign chip_idx = base_cnt[SC_W-1:OVS_SH];
    assign done     = smp_en && base_cnt == LAST;

    // One agreement counter per code word; the sign picks the phase later.
    for (genvar c = 0; c < NCODES; c++) begin : g_acc
        logic [ACC_W-1:0] base;
        logic             hit;
        assign base       = sync ? '0 : acc[c];
        assign hit        = s == codes[c][chip_idx];
        assign acc_nxt[c] = base + ACC_W'(hit);

        always_ff @(posedge clk) begin
            if (rst) begin
                acc[c] <= '0;
            end else if (smp_en) begin
                acc[c] <= done ? '0 : acc_nxt[c];
            end else if (sync) begin
                acc[c] <= '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (smp_en) begin
            cnt <= done ? '0 : base_cnt + 1'b1;
        end else if (sync) begin
            cnt <= '0;
        end
    end

    sym_t             dec_sym;
    logic [STR_W-1:0] dec_str;

    pnsc_decider #(
        .SMP   (SMP),
        .ACC_W (ACC_W),
        .STR_W (STR_W)
    ) decider_i (
        .agree    (acc_nxt),
        .sym      (dec_sym),
        .strength (dec_str)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid    <= 1'b0;
            sym      <= '0;
            strength <= '0;
        end else begin
            valid <= done;
            if (done) begin
                sym      <= dec_sym;
                strength <= dec_str;
            end
        end
    end

endmodule

// File: rtl/pnsc_top.sv
module pnsc_top
    import pnsc_pkg::*;
#(
    parameter int CHIPS = 32,
    parameter int OVS   = 2,
    parameter int STR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [CHIPS-1:0] cfg_wdata,
    input  logic             tx_inv,
    input  logic             rx_inv,
    input  logic             tx_sym_valid,
    input  logic [2:0]       tx_sym,
    output logic             tx_ready,
    input  logic             chip_en,
    output logic             tx_chip,
    input  logic             smp_en,
    input  logic             rx_smp,
    input  logic             rx_sync,
    output logic             rx_valid,
    output logic [2:0]       rx_sym,
    output logic [STR_W-1:0] rx_strength
);

    logic [NCODES-1:0][CHIPS-1:0] codes;

    pnsc_code_bank #(.CHIPS(CHIPS)) bank_i (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .codes (codes)
    );

    pnsc_tx_spreader #(.CHIPS(CHIPS)) tx_i (
        .clk       (clk),
        .rst       (rst),
        .codes     (codes),
        .tx_inv    (tx_inv),
        .sym_valid (tx_sym_valid),
        .sym       (tx_sym),
        .ready     (tx_ready),
        .chip_en   (chip_en),
        .chip      (tx_chip)
    );

    pnsc_rx_correlator #(.CHIPS(CHIPS), .OVS(OVS), .STR_W(STR_W)) rx_i (
        .clk      (clk),
        .rst      (rst),
        .codes    (codes),
        .rx_inv   (rx_inv),
        .smp_en   (smp_en),
        .smp      (rx_smp),
        .sync     (rx_sync),
        .valid    (rx_valid),
        .sym      (rx_sym),
        .strength (rx_strength)
    );

endmodule

// File: rtl/pnsc_checker.sv
module pnsc_checker #(
    parameter int STR_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_sym_valid,
    input logic             tx_ready,
    input logic             chip_en,
    input logic             tx_chip,
    input logic             tx_inv,
    input logic             smp_en,
    input logic             rx_sync,
    input logic             rx_valid,
    input logic [2:0]       rx_sym,
    input logic [STR_W-1:0] rx_strength
);

    // R3: without a strobe or a load, the chip output holds unless polarity changes.
    p_chip_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!chip_en && !tx_sym_valid) |=> ($stable(tx_chip) || !$stable(tx_inv)));

    // R4: right after a symbol is taken, the transmitter is busy.
    p_busy_after_take_r4: assert property (@(posedge clk) disable iff (rst)
        (tx_sym_valid && tx_ready) |=> !tx_ready);

    // R9: the decode pulse lasts one cycle.
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R9: results hold between pulses.
    p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !smp_en |=> ($stable(rx_sym) && $stable(rx_strength)));

    // R9/R10: no pulse without a sample strobe at the previous edge.
    p_valid_needs_sample_r10: assert property (@(posedge clk) disable iff (rst)
        !smp_en |=> !rx_valid);

endmodule

bind pnsc_top pnsc_checker #(.STR_W(STR_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .tx_sym_valid (tx_sym_valid),
    .tx_ready     (tx_ready),
    .chip_en      (chip_en),
    .tx_chip      (tx_chip),
    .tx_inv       (tx_inv),
    .smp_en       (smp_en),
    .rx_sync      (rx_sync),
    .rx_valid     (rx_valid),
    .rx_sym       (rx_sym),
    .rx_strength  (rx_strength)
);

// File: tb/pnsc_top_tb.sv
module pnsc_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [1:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        tx_inv, rx_inv;
    logic        tx_sym_valid;
    logic [2:0]  tx_sym;
    logic        tx_ready;
    logic        chip_en;
    logic        tx_chip;
    logic        smp_en, rx_smp, rx_sync;
    logic        rx_valid;
    logic [2:0]  rx_sym;
    logic [3:0]  rx_strength;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] bcode [4];

    always #5 clk = ~clk;

    pnsc_top dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .tx_inv(tx_inv), .rx_inv(rx_inv), .tx_sym_valid(tx_sym_valid), .tx_sym(tx_sym),
        .tx_ready(tx_ready), .chip_en(chip_en), .tx_chip(tx_chip), .smp_en(smp_en),
        .rx_smp(rx_smp), .rx_sync(rx_sync), .rx_valid(rx_valid), .rx_sym(rx_sym),
        .rx_strength(rx_strength)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Code index and phase from the symbol (R2).
    function automatic int sym_idx(input int s);
        return (s >= 4) ? (3 - (s % 4)) : s;
    endfunction

    function automatic bit exp_chip(input int s, input int k, input bit inv);
        bit b;
        b = bcode[sym_idx(s)][k];
        if (s >= 4) b = ~b;
        return b ^ inv;
    endfunction

    // Receive decision from the requirements (R7, R8).
    task automatic model_rx(input logic [63:0] line, output int esym, output int estr);
        int best_m, best_c;
        bit best_n;
        best_m = -1; best_c = 0; best_n = 1'b0;
        for (int c = 0; c < 4; c++) begin
            int a, m;
            a = 0;
            for (int j = 0; j < 64; j++) if (line[j] == bcode[c][j/2]) a++;
            m = (a >= 32) ? a - 32 : 32 - a;
            if (m > best_m) begin
                best_m = m; best_c = c; best_n = (a < 32);
            end
        end
        esym = best_n ? 4 + (3 - best_c) : best_c;
        estr = (best_m / 2 > 15) ? 15 : best_m / 2;
    endtask

    task automatic write_code(input int a, input logic [31:0] v);
        cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = v;
        step();
        cfg_we = 1'b0;
        bcode[a] = v;
    endtask

    // Back-to-back transmission of all eight symbols (R2..R5).
    task automatic run_tx(input bit inv);
        tx_inv = inv;
        step();
        chk(tx_ready == 1'b1, "R4 idle ready", int'(tx_ready), 1);
        tx_sym_valid = 1'b1; tx_sym = 3'd0;
        step();
        tx_sym_valid = 1'b0;
        for (int i = 0; i < 8; i++) begin
            for (int k = 0; k < 32; k++) begin
                step();
                chk(tx_chip == exp_chip(i, k, inv), $sformatf("R2/R3 sym %0d chip %0d inv %0d", i, k, inv),
                    int'(tx_chip), int'(exp_chip(i, k, inv)));
                if (k == 10) begin
                    // R5: offered while busy, must be ignored
                    tx_sym_valid = 1'b1; tx_sym = 3'(7 - i);
                end
                chip_en = 1'b1;
                #1;
                if (k == 31) begin
                    chk(tx_ready == 1'b1, "R4 ready on last chip", int'(tx_ready), 1);
                    if (i < 7) begin
                        tx_sym_valid = 1'b1; tx_sym = 3'(i + 1);
                    end
                end else if (k == 5) begin
                    chk(tx_ready == 1'b0, "R4 busy mid symbol", int'(tx_ready), 0);
                end
                step();
                chip_en = 1'b0; tx_sym_valid = 1'b0;
            end
        end
        chk(tx_ready == 1'b1, "R4 ready after last symbol", int'(tx_ready), 1);
        chk(tx_chip == 1'b0, "R3 idle chip", int'(tx_chip), 0);
    endtask

    // One full window; phys is what appears on rx_smp.
    task automatic send_window(input logic [63:0] phys, input bit first_with_sync);
        for (int j = 0; j < 64; j++) begin
            rx_smp = phys[j]; smp_en = 1'b1;
            rx_sync = (j == 0) && first_with_sync;
            step();
            smp_en = 1'b0; rx_sync = 1'b0;
            if (j == 62) chk(rx_valid == 1'b0, "R9 no early valid", int'(rx_valid), 0);
            if (j < 63) step();
        end
    endtask

    task automatic rx_case(input logic [63:0] line, input bit inv, input string tag);
        int es, est;
        model_rx(line, es, est);
        rx_inv = inv;
        send_window(line ^ {64{inv}}, 1'b0);
        chk(rx_valid == 1'b1, {"R9 valid ", tag}, int'(rx_valid), 1);
        chk(int'(rx_sym) == es, {"R6/R7 symbol ", tag}, int'(rx_sym), es);
        chk(int'(rx_strength) == est, {"R8 strength ", tag}, int'(rx_strength), est);
        step();
        chk(rx_valid == 1'b0, {"R9 pulse ends ", tag}, int'(rx_valid), 0);
        chk(int'(rx_sym) == es, {"R9 symbol held ", tag}, int'(rx_sym), es);
    endtask

    function automatic logic [63:0] clean_line(input int s);
        logic [63:0] l;
        for (int j = 0; j < 64; j++) l[j] = exp_chip(s, j / 2, 1'b0);
        return l;
    endfunction

    function automatic logic [63:0] flips(input int n, input int seed);
        logic [63:0] f;
        for (int j = 0; j < 64; j++) f[j] = ((j * 7 + seed) % 64) < n;
        return f;
    endfunction

    initial begin
        int flip_n [5] = '{0, 6, 14, 24, 40};
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        tx_inv = 1'b0; rx_inv = 1'b0; tx_sym_valid = 1'b0; tx_sym = '0;
        chip_en = 1'b0; smp_en = 1'b0; rx_smp = 1'b0; rx_sync = 1'b0;
        for (int a = 0; a < 4; a++) bcode[a] = '0;
        repeat (3) step();
        rst = 1'b0;
        step();
        chk(tx_ready == 1'b1, "R11 reset ready", int'(tx_ready), 1);
        chk(tx_chip == 1'b0, "R11 reset chip", int'(tx_chip), 0);
        chk(rx_valid == 1'b0, "R11 reset valid", int'(rx_valid), 0);
        chk(rx_sym == 3'd0 && rx_strength == 4'd0, "R11 reset result",
            int'({rx_sym, rx_strength}), 0);

        // R1: load four distinct code words
        write_code(0, 32'hA5C3_0F96);
        write_code(1, 32'h3C69_D28B);
        write_code(2, 32'h0FF0_5A17);
        write_code(3, 32'hE21D_7B44);

        run_tx(1'b0);
        run_tx(1'b1);

        for (int inv = 0; inv < 2; inv++)
            for (int s = 0; s < 8; s++)
                for (int f = 0; f < 5; f++)
                    rx_case(clean_line(s) ^ flips(flip_n[f], s * 5 + f), 1'(inv),
                            $sformatf("sym %0d flips %0d inv %0d", s, flip_n[f], inv));

        // R10: partial window discarded, coincident sample kept as sample 0
        rx_inv = 1'b0;
        for (int j = 0; j < 20; j++) begin
            rx_smp = 1'(j % 3 == 0); smp_en = 1'b1;
            step();
            smp_en = 1'b0;
        end
        chk(rx_valid == 1'b0, "R10 no valid from partial", int'(rx_valid), 0);
        begin
            int es, est;
            logic [63:0] l;
            l = clean_line(5) ^ flips(6, 3);
            model_rx(l, es, est);
            send_window(l, 1'b1);
            chk(rx_valid == 1'b1, "R10 valid after restart", int'(rx_valid), 1);
            chk(int'(rx_sym) == es, "R10 symbol after restart", int'(rx_sym), es);
            chk(int'(rx_strength) == est, "R10 strength after restart", int'(rx_strength), est);
        end

        // R1: rewrite one code word and see it take effect on both sides
        write_code(1, 32'h5555_AAAA);
        rx_case(clean_line(6), 1'b0, "after rewrite R1");
        tx_inv = 1'b0;
        tx_sym_valid = 1'b1; tx_sym = 3'd1;
        step();
        tx_sym_valid = 1'b0;
        for (int k = 0; k < 32; k++) begin
            chk(tx_chip == exp_chip(1, k, 1'b0), "R1 rewritten code on tx", int'(tx_chip),
                int'(exp_chip(1, k, 1'b0)));
            chip_en = 1'b1;
            step();
            chip_en = 1'b0;
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule